// File: doc/BRIEF.md
# 1-Wire ROM Command Selector

This block forms the ROM-function layer of a 1-Wire slave. It sits between a bit-timing layer and the memory-command layer. The bit-timing layer delivers each bit the master writes as a one-cycle receive strobe. It also carries out each bit the block offers on a transmit handshake. The block holds a 64-bit registration code, supplied on an input port. The code is read least significant bit first: an 8-bit family code, then a 48-bit serial number, then an 8-bit check byte.

Each time the bit-timing layer reports a completed reset and presence sequence, the block gathers the next eight received bits into a ROM command byte. It then does one of four things. It can stream its code out. It can compare a 64-bit code sent by the master with its own. It can join a bit-by-bit search in which several slaves drive the open-drain line at once, so that their bits combine as a wired-AND. Or it can skip the code exchange altogether. When the exchange succeeds it raises `selected`, which hands the line to the memory-command layer until the next bus reset. When the exchange fails, or the command byte is unknown, the block goes quiet until the next bus reset.

The states are as follows. `ST_IDLE` waits for a bus reset. `ST_CMD` gathers the command byte. `ST_READ` transmits the code. `ST_MATCH` compares received code bits. In a search, `ST_S_BIT` sends the true bit, `ST_S_CMP` sends its complement and `ST_S_DIR` reads the direction bit the master writes. `ST_SEL` is the selected state.

A bus reset moves any state to `ST_CMD`. From `ST_CMD`, the last command bit leads to `ST_READ` (33h), `ST_MATCH` (55h), `ST_SEL` (CCh), `ST_S_BIT` (F0h) or `ST_IDLE` (any other value). `ST_READ` goes to `ST_SEL` after 64 bits. `ST_MATCH` goes to `ST_IDLE` on the first differing bit, or to `ST_SEL` after 64 equal bits. The search states cycle `ST_S_BIT` → `ST_S_CMP` → `ST_S_DIR` → `ST_S_BIT`. `ST_S_DIR` leaves to `ST_IDLE` on a differing direction bit, or to `ST_SEL` after bit 63.

Top module: `onewire_rom_sel`

## Requirements
- R1: After `rst_n` is released the block waits for a bus reset: `selected` is 0, `tx_valid` is 0, and received bits are ignored (the command byte CCh sent before any bus reset selects nothing).
- R2: A `bus_reset` pulse in any state clears `selected` and `tx_valid` on the next cycle. The next eight received bits then form the command byte, with the first received bit as bit 0.
- R3: Command 33h makes the block offer its code bits in order, bit 0 first and bit 63 last. Each bit is held on `tx_bit` with `tx_valid` high until a `tx_done` pulse. After bit 63 the block is selected.
- R4: Command 55h makes the block compare each of the next 64 received bits with its own code, bit 0 first. If all 64 are equal, `selected` rises in the cycle after the 64th bit is received.
- R5: In a match, the first received bit that differs from the code sends the block idle. From then until a bus reset, `selected` stays 0, `tx_valid` stays 0 and further received bits have no effect.
- R6: Command CCh raises `selected` in the cycle after the eighth command bit, with no code exchange.
- R7: Command F0h starts a search. For each code bit i, starting at 0, the block offers bit i, then its complement, and then reads one received bit. A received bit equal to bit i moves the block on to bit i+1.
- R8: In a search, a received direction bit that differs from the block's own bit sends the block idle. Nothing more is offered, and `selected` stays 0 until a bus reset.
- R9: A search whose 64 direction bits all equal the block's code raises `selected` in the cycle after the last direction bit.
- R10: A command byte other than 33h, 55h, CCh or F0h sends the block idle until a bus reset: it offers no bits and is not selected.
- R11: While `selected` is 1 the block offers no bits and ignores received bits. `selected` holds until a bus reset.
- R12: While `tx_valid` is 1 and no `tx_done` or `bus_reset` arrives, `tx_valid` stays 1 and `tx_bit` does not change.
- R13: `selected` and `tx_valid` only rise in the cycle after a received bit or a `tx_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle pulse: a reset and presence sequence has completed |
| rx_valid | input | 1 | One-cycle strobe: a bit written by the master is on `rx_bit` |
| rx_bit | input | 1 | Received bit value |
| tx_valid | output | 1 | The block offers `tx_bit` for the next read slot |
| tx_bit | output | 1 | Bit to drive (0 pulls the line low) |
| tx_done | input | 1 | One-cycle pulse: the offered bit has been sent |
| rom_code | input | 64 | Registration code: bits 7:0 family, 55:8 serial, 63:56 check byte |
| selected | output | 1 | Slave is addressed; the memory-command layer owns the line |

## Verification
The checker watches four properties on every cycle. A bus reset clears both outputs. A selected block never offers a bit. An offered bit stays stable until it is consumed. Selection and transmit requests only begin after a bit event. What these properties cannot show is the bench's work: that the bytes 33h, 55h, CCh and F0h each choose the right exchange, that code bits come out in order with true and complement pairs, and that a mismatch at a given bit leaves the block silent. It also shows that unknown commands, bits received before any bus reset and bits received while selected are all ignored.

// File: rtl/onewire_rom_pkg.sv
package onewire_rom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;

    typedef enum logic [2:0] {
        RC_READ,
        RC_MATCH,
        RC_SKIP,
        RC_SEARCH,
        RC_NONE
    } rom_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_S_BIT,
        ST_S_CMP,
        ST_S_DIR,
        ST_SEL
    } rom_state_e;

endpackage

// File: rtl/onewire_cmd_decode.sv
module onewire_cmd_decode
    import onewire_rom_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_byte,
    output rom_cmd_e         cmd_kind
);

    always_comb begin
        unique case (cmd_byte)
            OP_READ:   cmd_kind = RC_READ;
            OP_MATCH:  cmd_kind = RC_MATCH;
            OP_SKIP:   cmd_kind = RC_SKIP;
            OP_SEARCH: cmd_kind = RC_SEARCH;
            default:   cmd_kind = RC_NONE;
        endcase
    end

endmodule

// File: rtl/onewire_rom_sel.sv
module onewire_rom_sel
    import onewire_rom_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            rx_valid,
    input  logic            rx_bit,
    output logic            tx_valid,
    output logic            tx_bit,
    input  logic            tx_done,
    input  logic [ID_W-1:0] rom_code,
    output logic            selected
);

    localparam int IDX_W = $clog2(ID_W);
    localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_W - 1);

    rom_state_e       state, state_nx;
    logic [IDX_W-1:0] cnt, cnt_nx;
    logic [CMD_W-1:0] cmd_sr, cmd_sr_nx, cmd_shift;
    rom_cmd_e         cmd_kind;
    logic             code_bit;
    logic             id_last;

    assign cmd_shift = {rx_bit, cmd_sr[CMD_W-1:1]};
    assign code_bit  = rom_code[cnt];
    assign id_last   = (cnt == LAST_ID);

    onewire_cmd_decode u_dec (
        .cmd_byte (cmd_shift),
        .cmd_kind (cmd_kind)
    );

    // next-state logic
    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        cmd_sr_nx = cmd_sr;
        if (bus_reset) begin
            state_nx  = ST_CMD;
            cnt_nx    = '0;
            cmd_sr_nx = '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SEL: ;
                ST_CMD: if (rx_valid) begin
                    cmd_sr_nx = cmd_shift;
                    if (cnt == LAST_CMD) begin
                        cnt_nx = '0;
                        unique case (cmd_kind)
                            RC_READ:   state_nx = ST_READ;
                            RC_MATCH:  state_nx = ST_MATCH;
                            RC_SKIP:   state_nx = ST_SEL;
                            RC_SEARCH: state_nx = ST_S_BIT;
                            default:   state_nx = ST_IDLE;
                        endcase
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                ST_READ: if (tx_done) begin
                    if (id_last) state_nx = ST_SEL;
                    else         cnt_nx   = cnt + 1'b1;
                end
                ST_MATCH: if (rx_valid) begin
                    if (rx_bit != code_bit) state_nx = ST_IDLE;
                    else if (id_last)       state_nx = ST_SEL;
                    else                    cnt_nx   = cnt + 1'b1;
                end
                ST_S_BIT: if (tx_done) state_nx = ST_S_CMP;
                ST_S_CMP: if (tx_done) state_nx = ST_S_DIR;
                ST_S_DIR: if (rx_valid) begin
                    if (rx_bit != code_bit) state_nx = ST_IDLE;
                    else if (id_last)       state_nx = ST_SEL;
                    else begin
                        cnt_nx   = cnt + 1'b1;
                        state_nx = ST_S_BIT;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cmd_sr <= '0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            cmd_sr <= cmd_sr_nx;
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_bit   = 1'b1;
        selected = 1'b0;
        unique case (state)
            ST_READ, ST_S_BIT: begin
                tx_valid = 1'b1;
                tx_bit   = code_bit;
            end
            ST_S_CMP: begin
                tx_valid = 1'b1;
                tx_bit   = ~code_bit;
            end
            ST_SEL:  selected = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/onewire_rom_sel_chk.sv
module onewire_rom_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic rx_valid,
    input logic tx_done,
    input logic tx_valid,
    input logic tx_bit,
    input logic selected
);

    assert_busreset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!selected && !tx_valid));

    assert_sel_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> !tx_valid);

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done && !bus_reset) |=> (tx_valid && $stable(tx_bit)));

    assert_sel_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> $past(rx_valid || tx_done));

    assert_tx_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(rx_valid || tx_done));

endmodule

bind onewire_rom_sel onewire_rom_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .rx_valid  (rx_valid),
    .tx_done   (tx_done),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .selected  (selected)
);

// File: tb/onewire_rom_sel_tb.sv
`timescale 1ns/1ps
module onewire_rom_sel_tb;

    localparam logic [63:0] CODE = {8'hB7, 48'h1C9E44037A51, 8'h14};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_valid, tx_bit, selected;
    logic [63:0] rom_code = CODE;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_q [$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    onewire_rom_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .tx_valid  (tx_valid),
        .tx_bit    (tx_bit),
        .tx_done   (tx_done),
        .rom_code  (rom_code),
        .selected  (selected)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares each consumed bit against the scoreboard queue
    always @(posedge tx_done) begin
        bit e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3/R7 unexpected transmit", 1, 0);
        end else begin
            e = exp_q.pop_front();
            check(tx_valid && (tx_bit == e), "R3/R7/R12 tx bit", int'(tx_bit), int'(e));
        end
    end

    task automatic pulse_reset();
        @(negedge clk); #1 bus_reset = 1'b1;
        @(negedge clk); #1 bus_reset = 1'b0;
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); #1 rx_valid = 1'b1; rx_bit = b;
        @(negedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic take(input bit e);
        exp_q.push_back(e);
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        #1 tx_done = 1'b1;
        @(negedge clk); #1 tx_done = 1'b0;
    endtask

    task automatic quiet_check(input string tag, input bit exp_sel);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check(!tx_valid, {tag, " no transmit"}, int'(tx_valid), 0);
        check(selected == exp_sel, {tag, " selected"}, int'(selected), int'(exp_sel));
    endtask

    // search: diverge at bit stop_at (negative = never)
    task automatic do_search(input int stop_at);
        for (int i = 0; i < 64; i++) begin
            take(CODE[i]);
            take(~CODE[i]);
            if (i == stop_at) begin
                send_bit(~CODE[i]);
                break;
            end
            send_bit(CODE[i]);
        end
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!selected && !tx_valid, "R1 reset state", int'(selected | tx_valid), 0);
        #1 rst_n = 1'b1;
        // R1: command before any bus reset is ignored
        send_byte(8'hCC);
        quiet_check("R1 pre-reset command", 1'b0);

        // R6: skip
        pulse_reset();
        send_byte(8'hCC);
        @(negedge clk);
        check(selected, "R6 skip selects", int'(selected), 1);
        // R11: bits while selected ignored
        send_byte(8'h33);
        quiet_check("R11 selected ignores bits", 1'b1);

        // R3: read ROM
        pulse_reset();
        check(!selected, "R2 bus reset clears selected", int'(selected), 0);
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) take(CODE[i]);
        @(negedge clk);
        check(selected, "R3 selected after read", int'(selected), 1);

        // R2: bus reset in the middle of a read restarts command reception
        pulse_reset();
        send_byte(8'h33);
        for (int i = 0; i < 5; i++) take(CODE[i]);
        pulse_reset();
        check(!tx_valid, "R2 reset aborts read", int'(tx_valid), 0);
        send_byte(8'hCC);
        @(negedge clk);
        check(selected, "R2 new command after reset", int'(selected), 1);

        // R4: exact match
        pulse_reset();
        send_byte(8'h55);
        for (int i = 0; i < 63; i++) send_bit(CODE[i]);
        check(!selected, "R4 not selected before last bit", int'(selected), 0);
        send_bit(CODE[63]);
        check(selected, "R4 match selects", int'(selected), 1);

        // R5: mismatch at bit 9, then keep sending the rest
        pulse_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(i == 9 ? ~CODE[i] : CODE[i]);
        quiet_check("R5 mismatch idle", 1'b0);
        send_byte(8'hCC);
        quiet_check("R5 ignores skip without reset", 1'b0);

        // R7/R9: full search
        pulse_reset();
        send_byte(8'hF0);
        do_search(-1);
        @(negedge clk);
        check(selected, "R9 search selects", int'(selected), 1);

        // R8: search diverging at bit 3
        pulse_reset();
        send_byte(8'hF0);
        do_search(3);
        quiet_check("R8 search drop", 1'b0);
        send_bit(1'b1);
        quiet_check("R8 stays idle", 1'b0);

        // R10: unknown command
        pulse_reset();
        send_byte(8'h00);
        quiet_check("R10 unknown 00h", 1'b0);
        pulse_reset();
        send_byte(8'hF1);
        send_byte(8'hCC);
        quiet_check("R10 unknown F1h", 1'b0);

        check(exp_q.size() == 0, "R3/R7 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule